// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends data words on a serial line whose bit clock is driven by an external master. The host writes a word into a holding register. If nothing is shifting at that moment, the word goes straight into the shift register. The block then presents the word least significant bit first. Each falling edge of the external clock advances the output by one bit, so the master can sample on its rising edges. A second word written while the first is still going out waits in the holding register. It moves into the shift register at the falling edge that retires the last bit of the first word, so the two words go out with no gap between them.

The external clock goes through a two-flop synchronizer and then a falling-edge detector. Only after that does it reach the system clock domain and advance the bit counter. Several conditions must all hold before any transfer can happen: the synchronous mode enable and the port enable are set, the clock-source select chooses the external master, both receive enables are clear, and the transmit enable is set. Any other setting flushes both registers. A per-word 9-bit mode takes its extra bit from a separate ninth-bit register. That register is sampled at the moment the word is written.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `buf_empty` = 1, `shift_empty` = 1, `sdata_out` = 0, and `irq` equals `irq_en`.
- R2: A write on `hold_wr` has no effect unless all of these hold: `sync_mode_en` = 1, `port_en` = 1, `tx_en` = 1, `clk_from_master` = 0, `rx_single_en` = 0 and `rx_cont_en` = 0. While any of them fails, both registers stay empty and `sdata_out` stays 0.
- R3: A write accepted while the shift register is empty loads the shift register directly. Within three system clocks, `shift_empty` = 0, `buf_empty` stays 1, and `sdata_out` shows bit 0 of the word.
- R4: Bits go out least significant first. Each synchronized falling edge of `sclk_in` moves `sdata_out` to the next bit.
- R5: A write accepted while a word is shifting sets `buf_empty` = 0 until the falling edge that retires the last bit of the current word. At that edge the held word enters the shift register, `buf_empty` returns to 1, and `sdata_out` shows bit 0 of the held word.
- R6: When `nine_bit_en` = 1 at write time, the word is 9 bits long and its bit 8 is the value the ninth-bit register held at that write. The register is loaded by `bit9_wr` with `bit9_val`. Later changes to `nine_bit_en` or to the ninth-bit register do not affect a word already written.
- R7: `irq` = 1 exactly when `irq_en` = 1 and `buf_empty` = 1.
- R8: After the falling edge that retires the last bit, with nothing held, `shift_empty` = 1 and `sdata_out` returns to 0.
- R9: Clearing `tx_en` in the middle of a word empties both registers within two system clocks and drives `sdata_out` to 0. No bit of either word is sent after transmission is enabled again.
- R10: A write accepted while the holding register is full and the shift register is busy replaces the held word.
- R11: A rising edge of `sclk_in` never changes `sdata_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode_en | input | 1 | Selects synchronous operation |
| port_en | input | 1 | Serial port enable |
| clk_from_master | input | 1 | 1 selects an internal clock source; transfers need 0 |
| rx_single_en | input | 1 | Single-receive enable; must be 0 to transmit |
| rx_cont_en | input | 1 | Continuous-receive enable; must be 0 to transmit |
| tx_en | input | 1 | Transmit enable; clearing it aborts and flushes |
| nine_bit_en | input | 1 | Selects 9-bit words, sampled at write time |
| irq_en | input | 1 | Interrupt enable |
| bit9_wr | input | 1 | Strobe that loads the ninth-bit register |
| bit9_val | input | 1 | Value for the ninth-bit register |
| hold_wr | input | 1 | Strobe that writes `hold_data` as a new word |
| hold_data | input | DATA_W | Data word |
| sclk_in | input | 1 | External shift clock from the master |
| sdata_out | output | 1 | Serial data output |
| buf_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Shift register empty |
| irq | output | 1 | Interrupt request |

## Verification
A wrong holding-register state shows up on `buf_empty` and `irq` within a cycle of the write that causes it. It shows up on `sdata_out` no later than the falling edge that retires the current word, because that is when the wrong word, or no word at all, would appear. Errors in the bit counter or in the word length show as a wrong bit on the line, or as `shift_empty` rising one falling edge early or late. The bench therefore checks the line after every rising and every falling edge of every word. Gating and abort faults appear at once as a nonzero `sdata_out` or a cleared empty flag on a port that should be idle.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // Number of bits a word occupies on the line.
  function automatic int unsigned word_bits(input logic nine, input int unsigned dw);
    return nine ? dw + 1 : dw;
  endfunction
endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      fall <= 1'b0;
    end else begin
      prev <= chain[STAGES-1];
      fall <= prev & ~chain[STAGES-1];
    end
  end

  // A detected edge lasts one cycle only
  assert_fall_single_R4: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/sst_holding.sv
module sst_holding #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              fill,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_nine,
  input  logic              drain,
  input  logic              bit9_wr,
  input  logic              bit9_val,
  output logic              full,
  output logic [DATA_W:0]   frame,
  output logic              nine,
  output logic              bit9_q
);
  always_ff @(posedge clk) begin
    if (rst)          bit9_q <= 1'b0;
    else if (bit9_wr) bit9_q <= bit9_val;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      full  <= 1'b0;
      frame <= '0;
      nine  <= 1'b0;
    end else if (fill) begin
      full  <= 1'b1;
      frame <= {bit9_q, fill_data};
      nine  <= fill_nine;
    end else if (drain) begin
      full  <= 1'b0;
    end
  end

  assert_drain_needs_word_R5: assert property (@(posedge clk) disable iff (rst)
    drain |-> full);
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            adv,
  input  logic            load,
  input  logic [DATA_W:0] load_frame,
  input  logic            load_nine,
  output logic            busy,
  output logic            dout,
  output logic            last_edge
);
  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   last_cnt;
  logic               nine_q;

  assign last_cnt  = CNT_W'(sst_pkg::word_bits(nine_q, DATA_W) - 1);
  assign last_edge = busy & adv & (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sr     <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      dout   <= 1'b0;
      nine_q <= 1'b0;
    end else if (load) begin
      sr     <= load_frame;
      cnt    <= '0;
      busy   <= 1'b1;
      dout   <= load_frame[0];
      nine_q <= load_nine;
    end else if (busy && adv) begin
      if (cnt == last_cnt) begin
        busy <= 1'b0;
        dout <= 1'b0;
        cnt  <= '0;
      end else begin
        sr   <= sr >> 1;
        dout <= sr[1];
        cnt  <= cnt + 1'b1;
      end
    end
  end

  assert_idle_line_low_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !dout);
  assert_count_in_word_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= last_cnt);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_mode_en,
  input  logic              port_en,
  input  logic              clk_from_master,
  input  logic              rx_single_en,
  input  logic              rx_cont_en,
  input  logic              tx_en,
  input  logic              nine_bit_en,
  input  logic              irq_en,
  input  logic              bit9_wr,
  input  logic              bit9_val,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              sclk_in,
  output logic              sdata_out,
  output logic              buf_empty,
  output logic              shift_empty,
  output logic              irq
);
  logic            active, wr_ok, fall;
  logic            hold_full, hold_nine, bit9_q;
  logic [DATA_W:0] hold_frame;
  logic            shift_busy, last_edge, shift_free;
  logic            load_sh, fill, drain;
  logic [DATA_W:0] load_frame;
  logic            load_nine;

  // Transfers need every mode condition met (R2)
  assign active = sync_mode_en & port_en & ~clk_from_master &
                  ~rx_single_en & ~rx_cont_en & tx_en;
  assign wr_ok  = active & hold_wr;

  sst_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sclk_in), .fall(fall)
  );

  assign shift_free = ~shift_busy | last_edge;
  assign load_sh    = active & shift_free & (hold_full | wr_ok);
  assign drain      = hold_full & load_sh;
  assign fill       = wr_ok & (hold_full | ~shift_free);
  assign load_frame = hold_full ? hold_frame : {bit9_q, hold_data};
  assign load_nine  = hold_full ? hold_nine  : nine_bit_en;

  sst_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .flush(~active), .fill(fill),
    .fill_data(hold_data), .fill_nine(nine_bit_en), .drain(drain),
    .bit9_wr(bit9_wr), .bit9_val(bit9_val),
    .full(hold_full), .frame(hold_frame), .nine(hold_nine), .bit9_q(bit9_q)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .flush(~active), .adv(fall & active),
    .load(load_sh), .load_frame(load_frame), .load_nine(load_nine),
    .busy(shift_busy), .dout(sdata_out), .last_edge(last_edge)
  );

  assign buf_empty   = ~hold_full;
  assign shift_empty = ~shift_busy;
  assign irq         = irq_en & buf_empty;

  assert_disable_flushes_R9: assert property (@(posedge clk) disable iff (rst)
    !active |=> buf_empty && shift_empty && !sdata_out);
  assert_held_implies_shifting_R5: assert property (@(posedge clk) disable iff (rst)
    hold_full |-> shift_busy);
  assert_direct_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !hold_full && !shift_busy) |=> shift_busy && !hold_full);
endmodule

// File: tb/tb_sync_slave_tx.sv
module tb_sync_slave_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_mode_en = 1'b0, port_en = 1'b0, clk_from_master = 1'b0;
  logic rx_single_en = 1'b0, rx_cont_en = 1'b0, tx_en = 1'b0;
  logic nine_bit_en = 1'b0, irq_en = 1'b0, bit9_wr = 1'b0, bit9_val = 1'b0;
  logic hold_wr = 1'b0, sclk_in = 1'b0;
  logic [7:0] hold_data = '0;
  logic sdata_out, buf_empty, shift_empty, irq;
  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sync_slave_tx dut (
    .clk(clk), .rst(rst), .sync_mode_en(sync_mode_en), .port_en(port_en),
    .clk_from_master(clk_from_master), .rx_single_en(rx_single_en),
    .rx_cont_en(rx_cont_en), .tx_en(tx_en), .nine_bit_en(nine_bit_en),
    .irq_en(irq_en), .bit9_wr(bit9_wr), .bit9_val(bit9_val),
    .hold_wr(hold_wr), .hold_data(hold_data), .sclk_in(sclk_in),
    .sdata_out(sdata_out), .buf_empty(buf_empty), .shift_empty(shift_empty),
    .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rise();
    sclk_in = 1'b1; tick(6);
  endtask
  task automatic fall();
    sclk_in = 1'b0; tick(6);
  endtask

  task automatic write_word(input logic [7:0] d);
    hold_data = d; hold_wr = 1'b1; tick(1); hold_wr = 1'b0; tick(2);
  endtask

  task automatic set_ninth(input logic v);
    bit9_val = v; bit9_wr = 1'b1; tick(1); bit9_wr = 1'b0;
  endtask

  // Send n bits of frame, checking the line after every edge
  task automatic shift_bits(input logic [8:0] f, input int n);
    for (int k = 0; k < n; k++) begin
      chk(sdata_out, f[k], "R4 bit before rise");
      rise();
      chk(sdata_out, f[k], "R11 rise keeps bit");
      fall();
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(shift_empty, 1, tag);
    chk(buf_empty, 1, tag);
    chk(sdata_out, 0, tag);
  endtask

  task automatic enable_all();
    sync_mode_en = 1; port_en = 1; tx_en = 1;
    clk_from_master = 0; rx_single_en = 0; rx_cont_en = 0;
  endtask

  initial begin
    tick(3); rst = 1'b0; tick(1);
    // R1 reset state
    chk(buf_empty, 1, "R1 buf_empty");
    chk(shift_empty, 1, "R1 shift_empty");
    chk(sdata_out, 0, "R1 sdata_out");
    chk(irq, 0, "R1 irq with irq_en=0");
    irq_en = 1; tick(1);
    chk(irq, 1, "R7 irq when empty");
    enable_all(); tick(2);

    // Every 8-bit value
    for (int v = 0; v < 256; v++) begin
      write_word(8'(v));
      chk(shift_empty, 0, "R3 shift loaded");
      chk(buf_empty, 1, "R3 buf stays empty");
      shift_bits({1'b0, 8'(v)}, 8);
      chk_idle("R8 idle after word");
    end

    // 9-bit words; mode and ninth bit changed after the write
    for (int v = 0; v < 256; v += 37) begin
      for (int n = 0; n < 2; n++) begin
        nine_bit_en = 1; set_ninth(n[0]);
        write_word(8'(v));
        set_ninth(~n[0]); nine_bit_en = 0;
        shift_bits({n[0], 8'(v)}, 9);
        chk_idle("R6 nine-bit word length");
      end
    end

    // Double buffer and interrupt
    write_word(8'hA5);
    write_word(8'h3C);
    chk(buf_empty, 0, "R5 held word");
    chk(irq, 0, "R7 irq low while held");
    shift_bits({1'b0, 8'hA5}, 7);
    rise();
    chk(buf_empty, 0, "R5 held until last edge");
    fall();
    chk(buf_empty, 1, "R5 empty after transfer");
    chk(shift_empty, 0, "R5 shift busy with second");
    chk(irq, 1, "R7 irq after transfer");
    shift_bits({1'b0, 8'h3C}, 8);
    chk_idle("R8 idle after pair");

    // Replacement of held word
    write_word(8'h11);
    write_word(8'h22);
    write_word(8'hC3);
    chk(buf_empty, 0, "R10 held");
    shift_bits({1'b0, 8'h11}, 8);
    shift_bits({1'b0, 8'hC3}, 8);
    chk_idle("R10 replaced word sent");

    // Abort mid-word
    write_word(8'hFF);
    write_word(8'hFF);
    shift_bits({1'b0, 8'hFF}, 3);
    tx_en = 0; tick(2);
    chk_idle("R9 abort flush");
    tx_en = 1; tick(2);
    for (int k = 0; k < 4; k++) begin
      rise(); fall();
      chk(sdata_out, 0, "R9 nothing after abort");
    end
    chk_idle("R9 still idle");

    // Gating: each condition wrong in turn
    for (int g = 0; g < 6; g++) begin
      enable_all();
      case (g)
        0: sync_mode_en = 0;
        1: port_en = 0;
        2: tx_en = 0;
        3: clk_from_master = 1;
        4: rx_single_en = 1;
        default: rx_cont_en = 1;
      endcase
      tick(1);
      write_word(8'hFF);
      chk_idle("R2 write ignored");
      rise(); fall();
      chk(sdata_out, 0, "R2 line quiet");
      enable_all(); tick(2);
      chk_idle("R2 nothing pending");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule